// File: doc/BRIEF.md
# Latched-Input Byte-Writable SRAM Controller

This block is a static RAM with 18-bit words and two optional input capture stages. Address and chip select share one capture stage. Write data has a second stage with its own enable. When an enable is high, its stage is transparent and the pin values act at once. When the enable is low, the stage keeps the value it took at the last clock edge that saw the enable high. If both enables are held high, the block acts as a plain asynchronous memory. If an enable is pulsed, the address or data is captured early in the cycle and the pins are free again.

The word is split into two 9-bit lanes. Each lane has its own active-low write strobe. The storage is written on the rising clock edge and read combinationally from the effective address. The bidirectional data pin is replaced by three signals: a write-data input, a read-data output and a drive flag that tells the pad ring when to turn the output buffer on. Depth is set by the address-width parameter. Set it to 16 for the full 64K words. The default is kept small so that the array stays cheap to elaborate.

Top module: `latched_byte_sram`

## Requirements
- R1: While `addr_le` is high, `addr_i` and `ce_n_i` take effect in the same cycle. A read shows the word at the new pin address before the next clock edge.
- R2: While `addr_le` is low, the block uses the address held at the last clock edge at which `addr_le` was high. A change on `addr_i` then changes neither the read word nor the write target.
- R3: While `din_le` is high, a write stores `wdata_i` from the pins. While `din_le` is low, a write stores the data held at the last edge at which `din_le` was high. This stage works independently of `addr_le`.
- R4: With both enables high, a write presented before an edge is visible at that address from the next cycle. No capture pulses are needed.
- R5: Chip select is captured together with the address. While `addr_le` is low, a change on `ce_n_i` has no effect.
- R6: `wr_n_i[0]` low writes only bits 8:0 of the effective word. `wr_n_i[1]` low writes only bits 17:9. The other lane keeps its contents.
- R7: When the effective chip select is high (deselected), no lane is written and `drive_o` is 0.
- R8: When the block is selected and both strobes are high, `drive_o` equals the inverse of `oe_n`. While `drive_o` is 1, `rdata_o` holds the stored word at the effective address. While `drive_o` is 0, `rdata_o` is all zeros.
- R9: While either strobe is low, `drive_o` is 0 whatever `oe_n` is.
- R10: Reset sets the held chip select to deselected and the held address and data to zero. Right after reset, with `addr_le` low, `drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; array write and stage capture edge |
| rst_n | input | 1 | Asynchronous active-low reset of the capture stages |
| addr_le | input | 1 | Address/chip-select stage enable, high = transparent |
| din_le | input | 1 | Write-data stage enable, high = transparent |
| addr_i | input | AW (10) | Word address |
| ce_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | LANES (2) | Active-low lane write strobes, bit 0 = bits 8:0 |
| oe_n | input | 1 | Active-low output enable |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Read data, zero when not driving |
| drive_o | output | 1 | Output buffer enable for the data pad |

## Verification
Reads, drive decisions and capture-stage transparency all resolve in the same cycle as the stimulus. The bench drives inputs just after the falling edge and samples the outputs a few nanoseconds later, well before the next rising edge. Writes and captured values take effect at the next rising edge. The bench's reference model therefore updates its array and held values only after that edge, using the inputs that were stable across it, so the next read is compared with the post-edge state.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   localparam int LBS_AW_DEF     = 10;
   localparam int LBS_LANE_W_DEF = 9;
   localparam int LBS_LANES_DEF  = 2;
endpackage

// File: rtl/lbs_capture.sv
module lbs_capture #(
   parameter int             W       = 8,
   parameter bit             BYPASS  = 1'b0,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (BYPASS) begin : g_wire
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, le};
         assign q = d;
      end else begin : g_hold
         logic [W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  held <= RST_VAL;
            else if (le) held <= d;
         end
         // transparent while enabled, otherwise the last captured value
         assign q = le ? d : held;
      end
   endgenerate
endmodule

// File: rtl/lbs_lane.sv
module lbs_lane #(
   parameter int AW = 10,
   parameter int W  = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/latched_byte_sram.sv
module latched_byte_sram #(
   parameter int AW         = lbs_pkg::LBS_AW_DEF,
   parameter int LANE_W     = lbs_pkg::LBS_LANE_W_DEF,
   parameter int LANES      = lbs_pkg::LBS_LANES_DEF,
   parameter bit ADDR_LATCH = 1'b1,
   parameter bit DATA_LATCH = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     addr_le,
   input  logic                     din_le,
   input  logic [AW-1:0]            addr_i,
   input  logic                     ce_n_i,
   input  logic [LANES-1:0]         wr_n_i,
   input  logic                     oe_n,
   input  logic [LANES*LANE_W-1:0]  wdata_i,
   output logic [LANES*LANE_W-1:0]  rdata_o,
   output logic                     drive_o
);
   localparam int DW = LANES * LANE_W;
   localparam int CW = AW + 1;

   generate
      if (AW < 1 || AW > 20) begin : g_bad_aw
         $error("latched_byte_sram: AW out of range");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("latched_byte_sram: lane shape invalid");
      end
   endgenerate

   logic [CW-1:0] ctl_eff;
   logic [DW-1:0] dat_eff;
   logic [DW-1:0] word;
   logic          sel;

   lbs_capture #(
      .W(CW), .BYPASS(!ADDR_LATCH), .RST_VAL({1'b1, {AW{1'b0}}})
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .le(addr_le),
      .d({ce_n_i, addr_i}), .q(ctl_eff)
   );

   lbs_capture #(
      .W(DW), .BYPASS(!DATA_LATCH), .RST_VAL('0)
   ) u_dat (
      .clk(clk), .rst_n(rst_n), .le(din_le),
      .d(wdata_i), .q(dat_eff)
   );

   assign sel = ~ctl_eff[CW-1];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         lbs_lane #(.AW(AW), .W(LANE_W)) u_lane (
            .clk(clk),
            .we(sel & ~wr_n_i[i]),
            .addr(ctl_eff[AW-1:0]),
            .wdata(dat_eff[i*LANE_W +: LANE_W]),
            .rdata(word[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign drive_o = sel & (&wr_n_i) & ~oe_n;
   assign rdata_o = drive_o ? word : '0;
endmodule

// File: rtl/latched_byte_sram_chk.sv
module latched_byte_sram_chk #(
   parameter int AW     = 10,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     addr_le,
   input logic                     ce_n_i,
   input logic [LANES-1:0]         wr_n_i,
   input logic                     oe_n,
   input logic [LANES*LANE_W-1:0]  rdata_o,
   input logic                     drive_o
);
   a_r9_strobe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !(&wr_n_i) |-> !drive_o);

   a_r7_deselect_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_le && ce_n_i) |-> !drive_o);

   a_r8_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!drive_o && rdata_o == '0));

   a_r2_hold_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !addr_le && $past(!addr_le) && $past(&wr_n_i)
       && drive_o && $past(drive_o)) |-> $stable(rdata_o));

   a_r10_reset_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && !addr_le) |-> !drive_o);
endmodule

bind latched_byte_sram latched_byte_sram_chk #(
   .AW(AW), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (.*);

// File: tb/latched_byte_sram_tb.sv
module latched_byte_sram_tb;
   localparam int AW = 10;
   localparam int DW = 18;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_le = 1'b0, din_le = 1'b0, ce_n_i = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic [1:0] wr_n_i = 2'b11;
   logic [DW-1:0] wdata_i = '0;
   logic [DW-1:0] rdata_o;
   logic drive_o;

   int n_chk = 0, n_fail = 0;

   logic [DW-1:0] m_mem [DEPTH];
   logic [AW-1:0] m_addr;
   logic          m_ce_n;
   logic [DW-1:0] m_data;

   always #10 clk = ~clk;

   latched_byte_sram u_dut (
      .clk(clk), .rst_n(rst_n), .addr_le(addr_le), .din_le(din_le),
      .addr_i(addr_i), .ce_n_i(ce_n_i), .wr_n_i(wr_n_i), .oe_n(oe_n),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
   );

   function automatic logic [AW-1:0] eff_addr();
      return addr_le ? addr_i : m_addr;
   endfunction
   function automatic logic eff_ce_n();
      return addr_le ? ce_n_i : m_ce_n;
   endfunction
   function automatic logic exp_drive();
      return !eff_ce_n() && (&wr_n_i) && !oe_n;
   endfunction
   function automatic logic [DW-1:0] exp_rdata();
      return exp_drive() ? m_mem[eff_addr()] : '0;
   endfunction

   task automatic check(input string tag);
      logic ed;
      logic [DW-1:0] er;
      ed = exp_drive();
      er = exp_rdata();
      n_chk++;
      if (drive_o !== ed) begin
         n_fail++;
         $display("FAIL %s drive_o actual %0b expected %0b", tag, drive_o, ed);
      end
      n_chk++;
      if (rdata_o !== er) begin
         n_fail++;
         $display("FAIL %s rdata_o actual %h expected %h", tag, rdata_o, er);
      end
   endtask

   // drive after the falling edge, check, then let the rising edge act
   task automatic step(input logic [AW-1:0] a, input logic ce, input logic ale,
                       input logic dle, input logic [1:0] wn, input logic oe,
                       input logic [DW-1:0] wd, input string tag);
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
      @(negedge clk);
      addr_i = a; ce_n_i = ce; addr_le = ale; din_le = dle;
      wr_n_i = wn; oe_n = oe; wdata_i = wd;
      #3;
      check(tag);
      ea = eff_addr();
      ed = dle ? wd : m_data;
      @(posedge clk);
      if (!eff_ce_n()) begin
         if (!wn[0]) m_mem[ea][8:0]  = ed[8:0];   // R6 lower lane
         if (!wn[1]) m_mem[ea][17:9] = ed[17:9];  // R6 upper lane
      end
      if (ale) begin m_addr = a; m_ce_n = ce; end
      if (dle) m_data = wd;
   endtask

   initial begin
      #3000000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] ra;
      logic [1:0] rw;
      string tg;
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 'x;
      m_addr = '0; m_ce_n = 1'b1; m_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: held select is deselected after reset
      step(10'd3, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, '0, "R10");
      // preload a small window with both stages transparent (R4)
      for (int i = 0; i < 16; i++)
         step(AW'(i), 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, DW'(18'h01000 + i * 18'h00111), "R4");
      step(10'd5, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, '0, "R4");
      // R1: new pin address read in the same cycle
      step(10'd7, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R1");
      step(10'd9, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R1");
      // R2: hold address 9, move pins
      step(10'd2, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, '0, "R2");
      step(10'd2, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 18'h2aaaa, "R2");
      step(10'd2, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, '0, "R2");
      step(10'd2, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R2");
      // R5: held select low, pin select high has no effect
      step(10'd4, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R5");
      step(10'd4, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, '0, "R5");
      // R3: capture data, change pins, write from held data
      step(10'd6, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 18'h15555, "R3");
      step(10'd6, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 18'h3ffff, "R3");
      step(10'd6, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R3");
      // R6: lane-only writes
      step(10'd8, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 18'h3c0ff, "R6");
      step(10'd8, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R6");
      step(10'd8, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 18'h0ab12, "R6");
      step(10'd8, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R6");
      // R7: deselected write stores nothing
      step(10'd1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 18'h12345, "R7");
      step(10'd1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R7");
      // R9: strobe low with oe low
      step(10'd1, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 18'h00777, "R9");
      step(10'd1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, '0, "R9");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         ra = AW'($urandom_range(0, 15));
         rw = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b11;
         if (!(&rw)) tg = "R9";
         else tg = "R8";
         step(ra, ($urandom_range(0, 5) == 0), 1'($urandom), 1'($urandom),
              rw, 1'($urandom), DW'($urandom), tg);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule